// File: doc/BRIEF.md
# CPU-Mapped Serial Flash Byte Port

This block sits in a cartridge mapper between an 8-bit CPU bus and a byte-addressable serial NOR flash. The CPU sees two locations: a control port and a data port. The control port holds the chip-select bit and a fetch-mode bit. The data port reaches a single byte buffer. That buffer is loaded with the outgoing byte when a transfer starts, and it ends the transfer holding the incoming byte. Software streams flash contents in one of two ways. In the first, it writes one data-port byte per fetch. In the second, it turns on auto-fetch, and then every data-port read hands back the buffered byte and starts the next transfer at once.

The buffer is shared, so reads run one transfer behind. Once the read command and the three address bytes have gone out, the first data read returns a stale byte and is discarded. Each later read returns the next flash byte in order. The shifter cannot be restarted while it is running. A duplicated read, for example one caused by a DMA cycle that repeats the CPU's bus access, therefore does not advance the flash address. CPU strobes count only after the M2 phase has been high on two consecutive system clocks. Each high phase yields exactly one access.

Top module: `spi_flash_port`

## Requirements
- R1: After reset, chip select is inactive (`flash_cs_n`=1), SCK is low, the control port reads 0x00 and the data port reads 0x00.
- R2: A control-port write sets chip select from data bit 0 (1 = selected, `flash_cs_n` low) and the mode from bit 1 (1 = auto-fetch, 0 = instructed-fetch). A control-port read returns busy in bit 7, mode in bit 1, chip select in bit 0, and zeros in the other bits.
- R3: A transfer moves 8 bits MSB first in SPI mode 0. SCK idles low, gives exactly 8 rising edges, MOSI changes only on falling edges, and MISO is sampled on rising edges. Busy reads 1 for the whole transfer.
- R4: In instructed-fetch mode, a data-port write while idle starts a transfer of the written byte. A data-port read has no side effect.
- R5: After a transfer ends, a data-port read returns the byte received during it (the shared buffer).
- R6: In auto-fetch mode, a data-port read while idle returns the buffered byte and starts a transfer that sends 0xFF. After a read command (0x03) and a 3-byte address, the first read is stale and each later read returns the next sequential flash byte.
- R7: Data-port reads and writes that arrive while busy start no transfer and do not disturb the transfer in progress.
- R8: An access counts only when M2 has been high for two consecutive clocks. A high phase of one clock does nothing, and one long high phase counts as one access.
- R9: In a program sequence (command 0x02, three address bytes, then 1 to 256 data bytes), the flash receives the data bytes in order, and releasing chip select ends the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than M2 |
| rst_n | input | 1 | Active-low synchronous reset |
| m2 | input | 1 | CPU phase clock; high marks a bus access |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| sel_data | input | 1 | Address decode for the data port (has priority) |
| sel_ctrl | input | 1 | Address decode for the control port |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, held stable through the M2 high phase |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Serial clock |
| flash_mosi | output | 1 | Serial data to the flash |
| flash_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume a bus that behaves like a real CPU. The select lines, `cpu_rnw` and `cpu_wdata` must stay steady for the whole time M2 is high, and each M2 phase must stay low for at least one clock between accesses. The bench drives every access with one task that sets the decode and data before M2 rises and drops them only after M2 falls. Its only deliberate violations are a single-clock M2 pulse, used to probe R8, and a second access placed inside a running transfer, used to probe R7. The flash model drives MISO only on falling SCK edges, which matches the mode-0 sampling the bounds assume.

// File: rtl/spi_flash_port_pkg.sv
package spi_flash_port_pkg;

    localparam int BYTE_W   = 8;
    localparam int CTL_CS   = 0;
    localparam int CTL_MODE = 1;
    localparam int CTL_BUSY = 7;
    localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;

    typedef struct packed {
        logic              cs;
        logic              mode;
        logic [BYTE_W-1:0] rd;
    } port_state_t;

endpackage

// File: rtl/cpu_access_qual.sv
module cpu_access_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic m2,
    output logic access_level,
    output logic access_pulse
);

    typedef struct packed {
        logic m2_dly;
        logic lvl;
    } qual_t;

    qual_t st_d, st_q;
    logic  qual;

    always_comb begin
        qual       = m2 & st_q.m2_dly;
        st_d       = st_q;
        st_d.m2_dly = m2;
        st_d.lvl    = qual;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign access_level = qual;
    assign access_pulse = qual & ~st_q.lvl;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        access_pulse |=> !access_pulse); // R8
    AST_PULSE_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        access_pulse |-> (m2 && $past(m2))); // R8

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] buf_byte
);

    localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);

    typedef struct packed {
        logic             busy;
        logic             sck;
        logic [DIV_W-1:0] div;
        logic [2:0]       bitcnt;
        logic [7:0]       shreg;
        logic             samp;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy   = 1'b1;
                st_d.sck    = 1'b0;
                st_d.div    = '0;
                st_d.bitcnt = '0;
                st_d.shreg  = tx_byte;
            end
        end else if (st_q.div == DIV_LAST) begin
            st_d.div = '0;
            if (!st_q.sck) begin
                st_d.sck  = 1'b1;
                st_d.samp = miso;
            end else begin
                st_d.sck   = 1'b0;
                st_d.shreg = {st_q.shreg[6:0], st_q.samp};
                if (st_q.bitcnt == 3'd7) st_d.busy = 1'b0;
                else                     st_d.bitcnt = st_q.bitcnt + 3'd1;
            end
        end else begin
            st_d.div = st_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign sck      = st_q.sck;
    assign mosi     = st_q.shreg[7];
    assign buf_byte = st_q.shreg;

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck); // R3
    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (mosi != $past(mosi))) |-> $fell(sck)); // R3
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (st_q.bitcnt >= $past(st_q.bitcnt))); // R7

endmodule

// File: rtl/spi_flash_port.sv
module spi_flash_port #(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       m2,
    input  logic       cpu_rnw,
    input  logic       sel_data,
    input  logic       sel_ctrl,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    output logic       flash_cs_n,
    output logic       flash_sck,
    output logic       flash_mosi,
    input  logic       flash_miso
);
    import spi_flash_port_pkg::*;

    port_state_t st_d, st_q;
    logic acc_lvl, acc_pulse;
    logic busy, start;
    logic [7:0] buf_byte, tx_byte, rd_mux;
    logic rd_ev, wr_ev;

    cpu_access_qual u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .m2           (m2),
        .access_level (acc_lvl),
        .access_pulse (acc_pulse)
    );

    spi_byte_engine #(.SCK_HALF(SCK_HALF)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tx_byte  (tx_byte),
        .miso     (flash_miso),
        .busy     (busy),
        .sck      (flash_sck),
        .mosi     (flash_mosi),
        .buf_byte (buf_byte)
    );

    always_comb begin
        rd_ev   = acc_pulse & cpu_rnw;
        wr_ev   = acc_pulse & ~cpu_rnw;
        start   = !busy && sel_data && (wr_ev || (rd_ev && st_q.mode));
        tx_byte = wr_ev ? cpu_wdata : FILL_BYTE;

        rd_mux = buf_byte;
        if (!sel_data && sel_ctrl) begin
            rd_mux           = '0;
            rd_mux[CTL_BUSY] = busy;
            rd_mux[CTL_MODE] = st_q.mode;
            rd_mux[CTL_CS]   = st_q.cs;
        end

        st_d = st_q;
        if (wr_ev && sel_ctrl && !sel_data) begin
            st_d.cs   = cpu_wdata[CTL_CS];
            st_d.mode = cpu_wdata[CTL_MODE];
        end
        if (!acc_lvl) st_d.rd = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_rdata  = st_q.rd;
    assign flash_cs_n = ~st_q.cs;

    AST_CS_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_pulse && !cpu_rnw && sel_ctrl && !sel_data) |=> (flash_cs_n == !$past(cpu_wdata[0]))); // R2
    AST_AUTO_READ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_pulse && cpu_rnw && sel_data && st_q.mode && !busy) |=> busy); // R6
    AST_INSTR_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_pulse && cpu_rnw && sel_data && !st_q.mode && !busy) |=> !busy); // R4
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_lvl && $past(acc_lvl)) |-> $stable(cpu_rdata)); // R8

endmodule

// File: tb/spi_flash_port_tb.sv
module spi_flash_port_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m2 = 1'b0, cpu_rnw = 1'b1, sel_data = 1'b0, sel_ctrl = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic flash_cs_n, flash_sck, flash_mosi;
    logic flash_miso = 1'b0;

    always #2.5 clk = ~clk;

    spi_flash_port u_dut (
        .clk(clk), .rst_n(rst_n), .m2(m2), .cpu_rnw(cpu_rnw),
        .sel_data(sel_data), .sel_ctrl(sel_ctrl), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .flash_cs_n(flash_cs_n), .flash_sck(flash_sck),
        .flash_mosi(flash_mosi), .flash_miso(flash_miso)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    function automatic logic [7:0] pat(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    // flash model
    logic [7:0] rx_sh, tx_sh, cmd;
    logic [23:0] addr;
    int nbits = 0, nbytes = 0, sck_rises = 0, prog_n = 0, committed = -1;
    logic [7:0] prog_mem [16];

    always @(negedge flash_cs_n) begin
        nbits = 0; nbytes = 0; tx_sh = 8'h00; flash_miso = 1'b0; prog_n = 0; committed = -1;
    end
    always @(posedge flash_cs_n) if (cmd == 8'h02) committed = prog_n;
    always @(posedge flash_sck) if (!flash_cs_n) begin
        rx_sh = {rx_sh[6:0], flash_mosi};
        sck_rises++;
    end
    always @(negedge flash_sck) if (!flash_cs_n) begin
        nbits++;
        if (nbits == 8) begin
            nbits = 0; nbytes++;
            case (nbytes)
                1: cmd = rx_sh;
                2: addr[23:16] = rx_sh;
                3: addr[15:8] = rx_sh;
                4: addr[7:0] = rx_sh;
                default: if (cmd == 8'h02 && prog_n < 16) begin
                    prog_mem[prog_n] = rx_sh; prog_n++;
                end
            endcase
            if (nbytes >= 4 && cmd == 8'h03) begin
                tx_sh = pat(addr); addr = addr + 24'd1;
            end else tx_sh = 8'h00;
        end else tx_sh = {tx_sh[6:0], 1'b0};
        flash_miso = tx_sh[7];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus(input logic rnw, input logic is_data, input logic [7:0] wd,
                       output logic [7:0] rd);
        @(negedge clk);
        cpu_rnw = rnw; sel_data = is_data; sel_ctrl = !is_data; cpu_wdata = wd; m2 = 1'b1;
        repeat (4) @(negedge clk);
        rd = cpu_rdata;
        m2 = 1'b0;
        repeat (2) @(negedge clk);
        sel_data = 1'b0; sel_ctrl = 1'b0; cpu_rnw = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        logic [7:0] r;
        for (int i = 0; i < 100; i++) begin
            bus(1'b1, 1'b0, 8'h00, r);
            if (!r[7]) return;
        end
        check("R3 busy never cleared", 1, 0);
    endtask

    task automatic wr_data(input logic [7:0] b);
        logic [7:0] r;
        bus(1'b0, 1'b1, b, r);
        wait_idle();
    endtask

    task automatic wr_ctrl(input logic [7:0] b);
        logic [7:0] r;
        bus(1'b0, 1'b0, b, r);
    endtask

    task automatic begin_read(input logic [23:0] a);
        wr_ctrl(8'h00);
        wr_ctrl(8'h01);
        wr_data(8'h03);
        wr_data(a[23:16]);
        wr_data(a[15:8]);
        wr_data(a[7:0]);
        wr_ctrl(8'h03);
    endtask

    localparam int NV = 4;
    localparam logic [23:0] VEC_ADDR [NV] = '{24'h000000, 24'h0012FE, 24'hABCDEF, 24'hFFFFFE};

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, r2;
        int s0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cs_n", flash_cs_n, 1);
        check("R1 sck", flash_sck, 0);
        bus(1'b1, 1'b0, 8'h00, r); check("R1 ctrl", r, 8'h00);
        bus(1'b1, 1'b1, 8'h00, r); check("R1 data", r, 8'h00);

        // R8 single-clock m2 pulse ignored
        @(negedge clk);
        cpu_rnw = 1'b0; sel_ctrl = 1'b1; cpu_wdata = 8'h01; m2 = 1'b1;
        @(negedge clk); m2 = 1'b0;
        repeat (3) @(negedge clk); sel_ctrl = 1'b0; cpu_rnw = 1'b1;
        check("R8 short m2 ignored", flash_cs_n, 1);

        // R2 control register
        wr_ctrl(8'hFE);
        check("R2 cs_n after bit0=0", flash_cs_n, 1);
        bus(1'b1, 1'b0, 8'h00, r); check("R2 ctrl readback mode", r, 8'h02);
        wr_ctrl(8'h01);
        check("R2 cs_n after bit0=1", flash_cs_n, 0);
        bus(1'b1, 1'b0, 8'h00, r); check("R2 ctrl readback cs", r, 8'h01);

        // R3/R7/R8: one transfer, writes while busy ignored
        s0 = sck_rises;
        bus(1'b0, 1'b1, 8'h9F, r);
        bus(1'b1, 1'b0, 8'h00, r); check("R3 busy bit during transfer", r[7], 1);
        bus(1'b0, 1'b1, 8'h11, r);
        wait_idle();
        check("R3 eight sck rises", sck_rises - s0, 8);
        check("R7 only one byte seen", nbytes, 1);
        check("R3 msb-first byte", cmd, 8'h9F);
        check("R3 sck idle low", flash_sck, 0);

        // R4/R5 instructed read of a known byte
        begin_read(24'h000100);
        wr_ctrl(8'h01);
        wr_data(8'hFF);
        s0 = nbytes;
        bus(1'b1, 1'b1, 8'h00, r);
        bus(1'b1, 1'b1, 8'h00, r2);
        check("R5 received byte", r, pat(24'h000100));
        check("R4 read repeats", r2, r);
        check("R4 read no transfer", nbytes, s0);

        // R6 vector table of auto-fetch streams
        for (int v = 0; v < NV; v++) begin
            begin_read(VEC_ADDR[v]);
            bus(1'b1, 1'b1, 8'h00, r);
            check("R6 stale first read", r, 8'h00);
            for (int k = 0; k < 3; k++) begin
                wait_idle();
                bus(1'b1, 1'b1, 8'h00, r);
                check("R6 sequential byte", r, pat(VEC_ADDR[v] + 24'(k)));
            end
            wait_idle();
        end

        // R7 duplicate read while busy keeps stream aligned
        begin_read(24'h004000);
        bus(1'b1, 1'b1, 8'h00, r);
        wait_idle();
        bus(1'b1, 1'b1, 8'h00, r);
        bus(1'b1, 1'b1, 8'h00, r2);
        check("R6 first data", r, pat(24'h004000));
        wait_idle();
        bus(1'b1, 1'b1, 8'h00, r);
        check("R7 alignment after duplicate", r, pat(24'h004001));
        wait_idle();

        // R9 program sequence
        wr_ctrl(8'h00);
        wr_ctrl(8'h01);
        wr_data(8'h02);
        wr_data(8'h00); wr_data(8'h20); wr_data(8'h00);
        for (int i = 0; i < 5; i++) wr_data(8'hC0 + 8'(i));
        check("R9 not committed while selected", committed, -1);
        wr_ctrl(8'h00);
        @(negedge clk);
        check("R9 committed count", committed, 5);
        for (int i = 0; i < 5; i++) check("R9 byte order", prog_mem[i], 8'hC0 + 8'(i));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule